// File: doc/BRIEF.md
# In-Order Retirement Ring with Rollback

The block is a circular buffer that holds every instruction between register renaming and retirement, so that a fault or a wrong branch guess can be undone exactly. Up to `LANES` instructions enter per cycle at the tail, in program order. Each slot records three things: the architectural destination, the newly assigned physical register and the physical register that destination was mapped to before. A slot's position in the ring is the instruction's tag. Execution units quote that tag when they report that an instruction has finished, and can flag the report as a fault.

Retirement runs from the head. Up to `LANES` finished slots leave per cycle, and retirement stops at the first slot that has not finished. For each retiring slot the block puts out its earlier physical register so that the free pool can take it back. A wrong branch guess discards every slot younger than the branch. A fault is acted on only once the faulting slot is the oldest, and it then discards everything in the ring. Discarded slots are popped from the tail one per cycle, youngest first. Each popped slot shows its destination, its earlier physical register (used to restore the rename map) and its new physical register. While this walk runs, nothing enters and nothing retires.

Top module: `commit_ring`

## Requirements
- R1: After reset the ring is empty: `free_slots` equals DEPTH, and `retire_valid`, `trap_take` and `unwind_busy` are all 0.
- R2: A request of `alloc_cnt` lanes (1 to LANES) is taken as a whole (`alloc_take`=1) when `alloc_cnt` <= `free_slots` and no rollback is running or starting. Lane i gets tag (tail + i) mod DEPTH and fills lanes of the flat buses at bit offset i*width. `free_slots` drops by `alloc_cnt` on the next cycle, less any slots retired in the same cycle.
- R3: When `alloc_cnt` exceeds `free_slots`, nothing is written: `alloc_take`=0, the offered tags stay the same and `free_slots` does not drop.
- R4: A pulse on `fin_valid[p]` marks the slot named by `fin_tag[p]` (bit offset p*IDX_W) as finished, and as faulted if `fin_fault[p]` is 1. The slot can retire from the next cycle on.
- R5: `retire_valid` is a thermometer code. Lane i is 1 exactly when slots head..head+i are all present, finished and not faulted. Lane i carries that slot's destination and earlier physical register, so retirement stops at the first unfinished slot and at LANES slots.
- R6: A mispredict on tag b removes the slots from tail-1 back to b+1, one per cycle, youngest first, with `unwind_busy`=1 and the popped slot's destination, earlier and new physical registers on the unwind outputs. Slot b stays. If b is the youngest slot, no walk starts.
- R7: When the head slot is finished and faulted, `trap_take` pulses for one cycle with `trap_tag`=head and nothing retires. Every slot, including the head, is then walked off youngest first, which leaves the ring empty. A trap outranks a mispredict in the same cycle.
- R8: In a cycle where a rollback runs, or a mispredict or trap starts one, no slot is allocated or retired. A mispredict that arrives while a walk runs is ignored.
- R9: Allocation and retirement in the same cycle both take effect: `free_slots` changes by (retired - allocated).
- R10: The ring wraps: tags run modulo DEPTH and the slot contents stay correct across repeated wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_cnt | input | LCNT_W | Number of lanes requesting entry this cycle |
| alloc_arch | input | LANES*ARCH_W | Architectural destination per lane |
| alloc_new_phys | input | LANES*PHYS_W | Newly assigned physical register per lane |
| alloc_old_phys | input | LANES*PHYS_W | Earlier physical mapping per lane |
| alloc_tag | output | LANES*IDX_W | Tag each lane would receive |
| alloc_take | output | 1 | The request is accepted this cycle |
| free_slots | output | IDX_W+1 | Number of empty slots |
| fin_valid | input | DONE_PORTS | Completion report per port |
| fin_fault | input | DONE_PORTS | Completion carries a fault |
| fin_tag | input | DONE_PORTS*IDX_W | Tag being completed per port |
| mispredict_valid | input | 1 | A branch was guessed wrong |
| mispredict_tag | input | IDX_W | Tag of that branch |
| retire_valid | output | LANES | Lanes retiring this cycle (thermometer) |
| retire_arch | output | LANES*ARCH_W | Destination of each retiring slot |
| retire_free_phys | output | LANES*PHYS_W | Earlier physical register to free |
| trap_take | output | 1 | Fault at the head is taken this cycle |
| trap_tag | output | IDX_W | Tag of the faulting slot |
| unwind_busy | output | 1 | A rollback walk is popping a slot |
| unwind_arch | output | ARCH_W | Destination of the popped slot |
| unwind_old_phys | output | PHYS_W | Mapping to restore for that destination |
| unwind_new_phys | output | PHYS_W | Physical register released by the pop |

## Verification
Allocation at the tail and retirement at the head can fall in the same cycle. A long sweep provokes this by offering new lanes on every cycle while completion reports, chosen pseudo-randomly and also in youngest-first order, build chains of finished slots behind the head. A bench-side model of the ring predicts, before each clock edge, the retired lane count, the freed registers, whether the request is accepted and the next `free_slots`. Each prediction is compared with the outputs. A second case makes a trap and a mispredict arrive in the same cycle. It is judged by whether the walk that follows removes every slot, not only those past the branch.

// File: rtl/commit_ring_pkg.sv
package commit_ring_pkg;

   typedef enum logic [0:0] {
      UW_IDLE = 1'b0,
      UW_WALK = 1'b1
   } uw_state_e;

endpackage

// File: rtl/cr_store.sv
module cr_store #(
   parameter int DEPTH      = 16,
   parameter int LANES      = 4,
   parameter int ARCH_W     = 5,
   parameter int PHYS_W     = 6,
   parameter int DONE_PORTS = 2,
   localparam int IDX_W     = $clog2(DEPTH)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [LANES-1:0]              wr_lane,
   input  logic [IDX_W-1:0]              wr_base,
   input  logic [LANES*ARCH_W-1:0]       wr_arch,
   input  logic [LANES*PHYS_W-1:0]       wr_new,
   input  logic [LANES*PHYS_W-1:0]       wr_old,
   input  logic [DONE_PORTS-1:0]         fin_valid,
   input  logic [DONE_PORTS-1:0]         fin_fault,
   input  logic [DONE_PORTS*IDX_W-1:0]   fin_tag,
   input  logic [IDX_W-1:0]              rd_base,
   output logic [LANES-1:0]              rd_done,
   output logic [LANES-1:0]              rd_fault,
   output logic [LANES*ARCH_W-1:0]       rd_arch,
   output logic [LANES*PHYS_W-1:0]       rd_old,
   input  logic [IDX_W-1:0]              tl_idx,
   output logic [ARCH_W-1:0]             tl_arch,
   output logic [PHYS_W-1:0]             tl_old,
   output logic [PHYS_W-1:0]             tl_new
);

   logic [ARCH_W-1:0] arch_q [DEPTH];
   logic [PHYS_W-1:0] new_q  [DEPTH];
   logic [PHYS_W-1:0] old_q  [DEPTH];
   logic [DEPTH-1:0]  done_q;
   logic [DEPTH-1:0]  fault_q;

   // payload: no reset needed, qualified by occupancy
   always_ff @(posedge clk) begin
      for (int l = 0; l < LANES; l++) begin
         if (wr_lane[l]) begin
            arch_q[IDX_W'(wr_base + IDX_W'(l))] <= wr_arch[l*ARCH_W +: ARCH_W];
            new_q [IDX_W'(wr_base + IDX_W'(l))] <= wr_new [l*PHYS_W +: PHYS_W];
            old_q [IDX_W'(wr_base + IDX_W'(l))] <= wr_old [l*PHYS_W +: PHYS_W];
         end
      end
   end

   // status: cleared on entry, set by completion ports
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_q  <= '0;
         fault_q <= '0;
      end else begin
         for (int l = 0; l < LANES; l++) begin
            if (wr_lane[l]) begin
               done_q [IDX_W'(wr_base + IDX_W'(l))] <= 1'b0;
               fault_q[IDX_W'(wr_base + IDX_W'(l))] <= 1'b0;
            end
         end
         for (int p = 0; p < DONE_PORTS; p++) begin
            if (fin_valid[p]) begin
               done_q [fin_tag[p*IDX_W +: IDX_W]] <= 1'b1;
               fault_q[fin_tag[p*IDX_W +: IDX_W]] <= fin_fault[p];
            end
         end
      end
   end

   for (genvar l = 0; l < LANES; l++) begin : g_rd
      logic [IDX_W-1:0] idx;
      assign idx                            = IDX_W'(rd_base + IDX_W'(l));
      assign rd_done[l]                     = done_q[idx];
      assign rd_fault[l]                    = fault_q[idx];
      assign rd_arch[l*ARCH_W +: ARCH_W]    = arch_q[idx];
      assign rd_old [l*PHYS_W +: PHYS_W]    = old_q[idx];
   end

   assign tl_arch = arch_q[tl_idx];
   assign tl_old  = old_q[tl_idx];
   assign tl_new  = new_q[tl_idx];

endmodule

// File: rtl/cr_retire.sv
module cr_retire #(
   parameter int DEPTH   = 16,
   parameter int LANES   = 4,
   localparam int IDX_W  = $clog2(DEPTH),
   localparam int CNT_W  = IDX_W + 1,
   localparam int LCNT_W = $clog2(LANES + 1)
) (
   input  logic              en,
   input  logic [CNT_W-1:0]  count,
   input  logic [LANES-1:0]  done,
   input  logic [LANES-1:0]  fault,
   output logic [LANES-1:0]  take,
   output logic [LCNT_W-1:0] take_n
);

   for (genvar i = 0; i < LANES; i++) begin : g_chain
      logic here_ok;
      assign here_ok = (CNT_W'(i) < count) && done[i] && !fault[i];
      if (i == 0) begin : g_first
         assign take[i] = en && here_ok;
      end else begin : g_next
         assign take[i] = take[i-1] && here_ok;
      end
   end

   always_comb begin
      take_n = '0;
      for (int i = 0; i < LANES; i++) begin
         take_n = take_n + LCNT_W'(take[i]);
      end
   end

endmodule

// File: rtl/cr_unwind.sv
module cr_unwind #(
   parameter int DEPTH  = 16,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [IDX_W-1:0] stop_in,
   input  logic [IDX_W-1:0] tail,
   output logic             busy,
   output logic             last
);
   import commit_ring_pkg::*;

   uw_state_e        state_q;
   logic [IDX_W-1:0] stop_q;

   assign busy = (state_q == UW_WALK);
   assign last = busy && (IDX_W'(tail - IDX_W'(1)) == stop_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= UW_IDLE;
         stop_q  <= '0;
      end else if (start && !busy) begin
         state_q <= UW_WALK;
         stop_q  <= stop_in;
      end else if (last) begin
         state_q <= UW_IDLE;
      end
   end

endmodule

// File: rtl/commit_ring.sv
module commit_ring #(
   parameter int DEPTH      = 16,
   parameter int LANES      = 4,
   parameter int ARCH_W     = 5,
   parameter int PHYS_W     = 6,
   parameter int DONE_PORTS = 2,
   localparam int IDX_W     = $clog2(DEPTH),
   localparam int CNT_W     = IDX_W + 1,
   localparam int LCNT_W    = $clog2(LANES + 1)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [LCNT_W-1:0]           alloc_cnt,
   input  logic [LANES*ARCH_W-1:0]     alloc_arch,
   input  logic [LANES*PHYS_W-1:0]     alloc_new_phys,
   input  logic [LANES*PHYS_W-1:0]     alloc_old_phys,
   output logic [LANES*IDX_W-1:0]      alloc_tag,
   output logic                        alloc_take,
   output logic [CNT_W-1:0]            free_slots,
   input  logic [DONE_PORTS-1:0]       fin_valid,
   input  logic [DONE_PORTS-1:0]       fin_fault,
   input  logic [DONE_PORTS*IDX_W-1:0] fin_tag,
   input  logic                        mispredict_valid,
   input  logic [IDX_W-1:0]            mispredict_tag,
   output logic [LANES-1:0]            retire_valid,
   output logic [LANES*ARCH_W-1:0]     retire_arch,
   output logic [LANES*PHYS_W-1:0]     retire_free_phys,
   output logic                        trap_take,
   output logic [IDX_W-1:0]            trap_tag,
   output logic                        unwind_busy,
   output logic [ARCH_W-1:0]           unwind_arch,
   output logic [PHYS_W-1:0]           unwind_old_phys,
   output logic [PHYS_W-1:0]           unwind_new_phys
);

   // elaboration-time parameter checks
   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2) begin : g_bad_depth
      $error("commit_ring: DEPTH must be a power of two, at least 2");
   end
   if (LANES < 1 || LANES > DEPTH) begin : g_bad_lanes
      $error("commit_ring: LANES must lie in 1..DEPTH");
   end
   if (DONE_PORTS < 1) begin : g_bad_ports
      $error("commit_ring: DONE_PORTS must be at least 1");
   end
   if (ARCH_W < 1 || PHYS_W < 1) begin : g_bad_widths
      $error("commit_ring: register widths must be positive");
   end

   logic [IDX_W-1:0]        head_q, tail_q, tail_m1, flush_keep, uw_stop;
   logic [CNT_W-1:0]        count_q;
   logic [LANES-1:0]        rd_done, rd_fault, wr_lane;
   logic [LCNT_W-1:0]       retire_n;
   logic                    trap_now, flush_now, uw_start, uw_last, retire_en;

   assign free_slots = CNT_W'(DEPTH) - count_q;
   assign tail_m1    = IDX_W'(tail_q - IDX_W'(1));
   assign flush_keep = IDX_W'(mispredict_tag + IDX_W'(1));

   // fault is acted on only at the oldest slot; outranks a mispredict
   assign trap_now  = !unwind_busy && (count_q != '0) && rd_done[0] && rd_fault[0];
   assign flush_now = mispredict_valid && !unwind_busy && !trap_now;
   assign uw_start  = trap_now || (flush_now && (flush_keep != tail_q));
   assign uw_stop   = trap_now ? head_q : flush_keep;
   assign retire_en = !unwind_busy && !flush_now;

   assign trap_take = trap_now;
   assign trap_tag  = head_q;

   assign alloc_take = !unwind_busy && !trap_now && !flush_now
                       && (alloc_cnt != '0)
                       && (alloc_cnt <= LCNT_W'(LANES))
                       && (CNT_W'(alloc_cnt) <= free_slots);

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign wr_lane[l]                   = alloc_take && (LCNT_W'(l) < alloc_cnt);
      assign alloc_tag[l*IDX_W +: IDX_W]  = IDX_W'(tail_q + IDX_W'(l));
   end

   cr_store #(
      .DEPTH(DEPTH), .LANES(LANES), .ARCH_W(ARCH_W),
      .PHYS_W(PHYS_W), .DONE_PORTS(DONE_PORTS)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_lane   (wr_lane),
      .wr_base   (tail_q),
      .wr_arch   (alloc_arch),
      .wr_new    (alloc_new_phys),
      .wr_old    (alloc_old_phys),
      .fin_valid (fin_valid),
      .fin_fault (fin_fault),
      .fin_tag   (fin_tag),
      .rd_base   (head_q),
      .rd_done   (rd_done),
      .rd_fault  (rd_fault),
      .rd_arch   (retire_arch),
      .rd_old    (retire_free_phys),
      .tl_idx    (tail_m1),
      .tl_arch   (unwind_arch),
      .tl_old    (unwind_old_phys),
      .tl_new    (unwind_new_phys)
   );

   cr_retire #(.DEPTH(DEPTH), .LANES(LANES)) u_retire (
      .en     (retire_en),
      .count  (count_q),
      .done   (rd_done),
      .fault  (rd_fault),
      .take   (retire_valid),
      .take_n (retire_n)
   );

   cr_unwind #(.DEPTH(DEPTH)) u_unwind (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (uw_start),
      .stop_in (uw_stop),
      .tail    (tail_q),
      .busy    (unwind_busy),
      .last    (uw_last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q  <= '0;
         tail_q  <= '0;
         count_q <= '0;
      end else begin
         head_q <= IDX_W'(head_q + IDX_W'(retire_n));
         if (unwind_busy) begin
            tail_q <= tail_m1;
         end else if (alloc_take) begin
            tail_q <= IDX_W'(tail_q + IDX_W'(alloc_cnt));
         end
         count_q <= count_q
                    + (alloc_take ? CNT_W'(alloc_cnt) : CNT_W'(0))
                    - CNT_W'(retire_n)
                    - (unwind_busy ? CNT_W'(1) : CNT_W'(0));
      end
   end

endmodule

// File: rtl/commit_ring_chk.sv
module commit_ring_chk #(
   parameter int DEPTH   = 16,
   parameter int LANES   = 4,
   localparam int IDX_W  = $clog2(DEPTH),
   localparam int CNT_W  = IDX_W + 1,
   localparam int LCNT_W = $clog2(LANES + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic [LCNT_W-1:0] alloc_cnt,
   input logic              alloc_take,
   input logic [CNT_W-1:0]  free_slots,
   input logic [LANES-1:0]  retire_valid,
   input logic              trap_take,
   input logic              unwind_busy,
   input logic              mispredict_valid
);

   p_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
      int'(free_slots) <= DEPTH);

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(alloc_cnt) > int'(free_slots)) |-> !alloc_take);

   p_thermo_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (retire_valid & LANES'(retire_valid + LANES'(1))) == '0);

   p_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      unwind_busy |=> int'(free_slots) == int'($past(free_slots)) + 1);

   p_trap_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      trap_take |-> (retire_valid == '0 && !alloc_take));

   p_trap_walk_r7: assert property (@(posedge clk) disable iff (!rst_n)
      trap_take |=> unwind_busy);

   p_walk_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      unwind_busy |-> (!alloc_take && retire_valid == '0));

   p_flush_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mispredict_valid && !unwind_busy) |-> (!alloc_take && retire_valid == '0));

endmodule

bind commit_ring commit_ring_chk #(.DEPTH(DEPTH), .LANES(LANES)) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .alloc_cnt        (alloc_cnt),
   .alloc_take       (alloc_take),
   .free_slots       (free_slots),
   .retire_valid     (retire_valid),
   .trap_take        (trap_take),
   .unwind_busy      (unwind_busy),
   .mispredict_valid (mispredict_valid)
);

// File: tb/commit_ring_bench.sv
`timescale 1ns/1ps
module commit_ring_bench;

   localparam int D  = 16;
   localparam int L  = 4;
   localparam int AW = 5;
   localparam int PW = 6;
   localparam int NP = 2;
   localparam int IW = 4;

   logic              clk = 1'b0;
   logic              rst_n;
   logic [2:0]        alloc_cnt;
   logic [L*AW-1:0]   alloc_arch;
   logic [L*PW-1:0]   alloc_new_phys, alloc_old_phys;
   logic [L*IW-1:0]   alloc_tag;
   logic              alloc_take;
   logic [IW:0]       free_slots;
   logic [NP-1:0]     fin_valid, fin_fault;
   logic [NP*IW-1:0]  fin_tag;
   logic              mispredict_valid;
   logic [IW-1:0]     mispredict_tag;
   logic [L-1:0]      retire_valid;
   logic [L*AW-1:0]   retire_arch;
   logic [L*PW-1:0]   retire_free_phys;
   logic              trap_take;
   logic [IW-1:0]     trap_tag;
   logic              unwind_busy;
   logic [AW-1:0]     unwind_arch;
   logic [PW-1:0]     unwind_old_phys, unwind_new_phys;

   always #2.5 clk = ~clk;

   commit_ring #(.DEPTH(D), .LANES(L), .ARCH_W(AW), .PHYS_W(PW), .DONE_PORTS(NP)) u_commit_ring (
      .clk(clk), .rst_n(rst_n),
      .alloc_cnt(alloc_cnt), .alloc_arch(alloc_arch),
      .alloc_new_phys(alloc_new_phys), .alloc_old_phys(alloc_old_phys),
      .alloc_tag(alloc_tag), .alloc_take(alloc_take), .free_slots(free_slots),
      .fin_valid(fin_valid), .fin_fault(fin_fault), .fin_tag(fin_tag),
      .mispredict_valid(mispredict_valid), .mispredict_tag(mispredict_tag),
      .retire_valid(retire_valid), .retire_arch(retire_arch),
      .retire_free_phys(retire_free_phys),
      .trap_take(trap_take), .trap_tag(trap_tag),
      .unwind_busy(unwind_busy), .unwind_arch(unwind_arch),
      .unwind_old_phys(unwind_old_phys), .unwind_new_phys(unwind_new_phys)
   );

   int checks = 0;
   int errors = 0;
   int m_seq [D];
   bit m_done [D];
   bit m_fault [D];
   int m_head = 0, m_tail = 0, m_count = 0, nseq = 1;
   logic [15:0] lfsr = 16'hACE1;

   function automatic int ea(int s); return s % 32; endfunction
   function automatic int en(int s); return (s * 7 + 3) % 64; endfunction
   function automatic int eo(int s); return (s * 5 + 1) % 64; endfunction
   function automatic int wrap(int x); return ((x % D) + D) % D; endfunction

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic clear_in();
      alloc_cnt = '0; alloc_arch = '0; alloc_new_phys = '0; alloc_old_phys = '0;
      fin_valid = '0; fin_fault = '0; fin_tag = '0;
      mispredict_valid = 1'b0; mispredict_tag = '0;
   endtask

   task automatic drive_alloc(int n);
      alloc_cnt = 3'(n);
      for (int i = 0; i < L; i++) begin
         alloc_arch    [i*AW +: AW] = AW'(ea(nseq + i));
         alloc_new_phys[i*PW +: PW] = PW'(en(nseq + i));
         alloc_old_phys[i*PW +: PW] = PW'(eo(nseq + i));
      end
   endtask

   task automatic drive_fin(int p, int tag, bit flt);
      fin_valid[p] = 1'b1;
      fin_fault[p] = flt;
      fin_tag[p*IW +: IW] = IW'(tag);
   endtask

   function automatic logic [15:0] step_lfsr(logic [15:0] v);
      return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
   endfunction

   // one ordinary cycle: predicts retire, allocation and occupancy
   task automatic cycle_normal(string req);
      int n;
      bit acc;
      int cnt;
      #1;
      n = 0;
      while (n < L && n < m_count && m_done[wrap(m_head + n)] && !m_fault[wrap(m_head + n)]) n++;
      cnt = int'(alloc_cnt);
      acc = (cnt != 0) && (cnt <= L) && (cnt <= D - m_count);
      chk({req, " R5"}, "retire_valid", int'(retire_valid), (1 << n) - 1);
      for (int i = 0; i < n; i++) begin
         chk({req, " R5"}, "retire_free_phys", int'(retire_free_phys[i*PW +: PW]),
             eo(m_seq[wrap(m_head + i)]));
         chk({req, " R5"}, "retire_arch", int'(retire_arch[i*AW +: AW]),
             ea(m_seq[wrap(m_head + i)]));
      end
      chk({req, " R9"}, "free_slots", int'(free_slots), D - m_count);
      chk({req, acc ? " R2" : " R3"}, "alloc_take", int'(alloc_take), int'(acc));
      chk({req, " R10"}, "alloc_tag lane0", int'(alloc_tag[IW-1:0]), m_tail);
      chk({req, " R2"}, "alloc_tag lane3", int'(alloc_tag[3*IW +: IW]), wrap(m_tail + 3));
      @(posedge clk);
      m_head = wrap(m_head + n);
      m_count -= n;
      if (acc) begin
         for (int i = 0; i < cnt; i++) begin
            m_seq[wrap(m_tail + i)]   = nseq + i;
            m_done[wrap(m_tail + i)]  = 1'b0;
            m_fault[wrap(m_tail + i)] = 1'b0;
         end
         m_tail = wrap(m_tail + cnt);
         m_count += cnt;
         nseq += cnt;
      end
      for (int p = 0; p < NP; p++) begin
         if (fin_valid[p]) begin
            m_done[int'(fin_tag[p*IW +: IW])]  = 1'b1;
            m_fault[int'(fin_tag[p*IW +: IW])] = fin_fault[p];
         end
      end
      #1;
      clear_in();
   endtask

   // walk checker shared by mispredict and trap
   task automatic check_walk(int removed, string req);
      for (int k = 0; k < removed; k++) begin
         int idx;
         idx = wrap(m_tail - 1);
         if (k == 0) begin
            mispredict_valid = 1'b1;
            mispredict_tag = IW'(m_head);
            drive_alloc(2);
         end
         #1;
         chk({req, " R6"}, "unwind_busy", int'(unwind_busy), 1);
         chk({req, " R6"}, "unwind_arch", int'(unwind_arch), ea(m_seq[idx]));
         chk({req, " R6"}, "unwind_old_phys", int'(unwind_old_phys), eo(m_seq[idx]));
         chk({req, " R6"}, "unwind_new_phys", int'(unwind_new_phys), en(m_seq[idx]));
         chk({req, " R8"}, "alloc_take in walk", int'(alloc_take), 0);
         chk({req, " R8"}, "retire_valid in walk", int'(retire_valid), 0);
         @(posedge clk);
         m_tail = idx;
         m_count--;
         #1;
         clear_in();
         chk({req, " R6"}, "free_slots after pop", int'(free_slots), D - m_count);
      end
      chk({req, " R8"}, "walk ended", int'(unwind_busy), 0);
   endtask

   task automatic do_mispredict(int tag);
      int removed;
      removed = wrap(m_tail - tag - 1);
      mispredict_valid = 1'b1;
      mispredict_tag = IW'(tag);
      drive_alloc(1);
      #1;
      chk("mispredict start R8", "alloc_take", int'(alloc_take), 0);
      chk("mispredict start R8", "retire_valid", int'(retire_valid), 0);
      @(posedge clk);
      #1;
      clear_in();
      if (removed == 0) chk("youngest branch R6", "unwind_busy", int'(unwind_busy), 0);
      check_walk(removed, "mispredict");
   endtask

   task automatic do_trap();
      while (m_count > 0 && m_done[m_head]) cycle_normal("drain before trap");
      while (m_count < 6) begin drive_alloc(3); cycle_normal("fill before trap"); end
      drive_fin(0, m_head, 1'b1);
      drive_fin(1, wrap(m_head + 1), 1'b0);
      cycle_normal("mark fault R4");
      mispredict_valid = 1'b1;
      mispredict_tag = IW'(wrap(m_head + 1));
      #1;
      chk("trap R7", "trap_take", int'(trap_take), 1);
      chk("trap R7", "trap_tag", int'(trap_tag), m_head);
      chk("trap R7", "retire_valid", int'(retire_valid), 0);
      @(posedge clk);
      #1;
      clear_in();
      chk("trap R7", "trap_take pulse ends", int'(trap_take), 0);
      check_walk(m_count, "trap R7");
      chk("trap R7", "ring empty", int'(free_slots), D);
      chk("trap R7", "tail back at head", m_tail, m_head);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      clear_in();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      #1;
      chk("reset R1", "free_slots", int'(free_slots), D);
      chk("reset R1", "retire_valid", int'(retire_valid), 0);
      chk("reset R1", "trap_take", int'(trap_take), 0);
      chk("reset R1", "unwind_busy", int'(unwind_busy), 0);

      // fill to full, including a rejected oversize request (R3)
      drive_alloc(4); cycle_normal("fill R2");
      drive_alloc(4); cycle_normal("fill R2");
      drive_alloc(4); cycle_normal("fill R2");
      drive_alloc(3); cycle_normal("fill R2");
      drive_alloc(2); cycle_normal("too big R3");
      chk("R3", "free_slots unchanged", int'(free_slots), 1);
      drive_alloc(1); cycle_normal("last slot R2");
      drive_alloc(1); cycle_normal("full R3");
      chk("R3", "still full", int'(free_slots), 0);

      // completions youngest first: nothing retires until head finishes (R4)
      for (int k = D - 1; k >= 1; k -= 2) begin
         drive_fin(0, wrap(m_head + k), 1'b0);
         drive_fin(1, wrap(m_head + k - 1), 1'b0);
         if (k == 1) fin_valid[1] = 1'b0;
         cycle_normal("young first R4");
      end
      drive_fin(0, m_head, 1'b0);
      cycle_normal("head done R4");
      // chain drains four per cycle while new lanes enter (R9)
      for (int c = 0; c < 6; c++) begin
         drive_alloc(2);
         cycle_normal("retire with alloc R9");
      end

      // pseudo-random sweep across many wraps (R10)
      for (int c = 0; c < 600; c++) begin
         lfsr = step_lfsr(lfsr);
         drive_alloc(int'(lfsr[2:0]) % 5);
         if (m_count > 0) begin
            drive_fin(0, wrap(m_head + int'(lfsr[7:4]) % m_count), 1'b0);
            if (m_count > 1 && lfsr[8])
               drive_fin(1, wrap(m_head + (int'(lfsr[7:4]) + 1 + int'(lfsr[11:9])) % m_count), 1'b0);
            if (fin_valid[1] && fin_tag[2*IW-1:IW] == fin_tag[IW-1:0]) fin_valid[1] = 1'b0;
         end
         cycle_normal("sweep R10");
         if (c == 200 && m_count > 3) do_mispredict(wrap(m_head + 1));
         if (c == 300 && m_count > 0) do_mispredict(wrap(m_tail - 1));
         if (c == 400 && m_count > 2) do_mispredict(m_head);
      end

      while (m_count < 10) begin drive_alloc(4); cycle_normal("refill R2"); end
      do_mispredict(wrap(m_head + 4));
      do_trap();

      for (int c = 0; c < 60; c++) begin
         drive_alloc(3);
         if (m_count > 0) drive_fin(0, m_head, 1'b0);
         cycle_normal("after trap R10");
      end
      while (m_count > 0) begin
         drive_fin(0, m_head, 1'b0);
         if (m_count > 1) drive_fin(1, wrap(m_head + 1), 1'b0);
         cycle_normal("final drain R5");
      end
      #1;
      chk("final R1", "empty", int'(free_slots), D);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule